// File: doc/BRIEF.md
# Dual-Table Receive Address Filter

This block decides whether an incoming frame is wanted by comparing two header fields against two small content-addressable tables. One table holds multicast destination MAC addresses. The other holds VLAN identifiers. A frame parser elsewhere supplies the 48-bit destination MAC, a tagged flag and the 12-bit VID with a one-cycle valid pulse. One clock later the block reports whether the multicast table hit, whether the VLAN check passed, and the overall accept decision.

Software loads both tables through a single byte-wide register port. The two tables share one control register, one index register, one 8-byte data window and one 32-bit entry mask. A select bit in the control register steers index, mask and strobe accesses to one table or the other. An entry is committed only when software sets the write strobe together with the enable bit. A read strobe copies the indexed entry back into the data window, so the tables can be read out. A configuration register turns VLAN filtering on and sets promiscuous mode.

Register map (4-bit address): 0x0-0x7 data window bytes 0-7, 0x8-0xB mask bytes 0-3 (byte k holds mask bits 8k+7..8k), 0xC control, 0xD index, 0xE configuration. All registers can be read at any time through `reg_rdata`.

Top module: `cam_rx_filter`

## Requirements
- R1: After reset the control, index, configuration, mask and data window registers all read 0 and `res_valid` is 0.
- R2: Control bit 0 is the enable, bit 1 selects the VLAN table (0 selects multicast), bit 2 is the write strobe and bit 3 is the read strobe. Writes to the index (0xD), data window (0x0-0x7) and mask (0x8-0xB) registers have no effect while the stored enable bit is 0.
- R3: Only the low 5 bits of the index are kept. Writing 0x25 reads back as 0x05, and entries are stored at the index modulo 32.
- R4: Writing the control register with enable and write strobe set commits the data window into the indexed entry of the selected table one clock later. A write strobe written with the enable bit clear commits nothing.
- R5: A multicast entry is data bytes 0-5, with byte 0 as MAC bits 47:40 and byte 5 as bits 7:0. A VLAN entry is 16 bits, with byte 6 as bits 7:0 and byte 7 as bits 15:8.
- R6: The strobe bits read back as set for exactly one cycle after the control write and then clear by themselves. The enable and select bits are kept.
- R7: Mask bit i enables entry i of the table chosen by the select bit. Mask reads return the selected table's mask. With a zero mask no entry of that table can match.
- R8: The multicast hit is set when the 48-bit destination MAC equals any entry whose mask bit is set. All 48 bits take part in the compare.
- R9: With VLAN filtering on (configuration bit 0), a tagged frame passes the VLAN check only if its VID equals the low 12 bits of an enabled VLAN entry. Untagged frames always pass, and with filtering off every frame passes.
- R10: In promiscuous mode (configuration bit 1) every valid frame is accepted.
- R11: A control write with enable and read strobe set loads the indexed entry of the selected table into the data window one clock later, at the same byte positions used for writes.
- R12: `res_valid` follows `frm_valid` by one clock. When `res_valid` is set, `res_accept` equals promiscuous OR (multicast hit AND VLAN pass). All result outputs are 0 when `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| frm_valid | input | 1 | Frame header fields valid |
| frm_dmac | input | 48 | Destination MAC address |
| frm_tagged | input | 1 | Frame carries a VLAN tag |
| frm_vid | input | 12 | VLAN identifier of the frame |
| res_valid | output | 1 | Result valid, one clock after `frm_valid` |
| res_mc_hit | output | 1 | Multicast table hit |
| res_vlan_ok | output | 1 | VLAN check passed |
| res_accept | output | 1 | Frame accepted |

## Verification
On every cycle the assertions check that a zero mask never produces a hit, that an entry holds its value unless committed and takes the data window exactly when committed, that strobes clear after one cycle, that the index ignores writes without enable, and that promiscuous mode and the accept equation hold at the result outputs. Only the bench scenarios can show the byte ordering of entries in the data window, index wrap-around, full 48-bit and low-12-bit compare widths, the select-bit steering of masks and readback, and that a strobe without enable leaves the table unchanged. The random rounds fill tables from index 0 with contiguous masks of varying length and mix frames drawn from the tables with unrelated ones.

// File: rtl/cam_filt_pkg.sv
package cam_filt_pkg;
   // control register bit positions
   localparam int unsigned CTL_EN  = 0;
   localparam int unsigned CTL_SEL = 1;
   localparam int unsigned CTL_WR  = 2;
   localparam int unsigned CTL_RD  = 3;
   // register addresses
   localparam logic [3:0] A_WIN0  = 4'h0;
   localparam logic [3:0] A_MASK0 = 4'h8;
   localparam logic [3:0] A_CTL   = 4'hC;
   localparam logic [3:0] A_IDX   = 4'hD;
   localparam logic [3:0] A_CFG   = 4'hE;
   // data window layout
   localparam int unsigned WIN_BYTES = 8;
   localparam int unsigned MC_BYTES  = 6;
   localparam int unsigned VL_LO     = 6;
   localparam int unsigned VL_HI     = 7;
   localparam int unsigned MAC_BITS  = 48;
   localparam int unsigned VL_BITS   = 16;
endpackage

// File: rtl/cam_filt_table.sv
module cam_filt_table #(
   parameter int unsigned ENTRIES    = 32,
   parameter int unsigned W          = 48,
   parameter int unsigned CMP_W      = 48,
   parameter int unsigned IDX_W      = $clog2(ENTRIES),
   parameter int unsigned MASK_BYTES = ENTRIES / 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      idx,
   input  logic [W-1:0]          wr_data,
   input  logic [MASK_BYTES-1:0] mask_we,
   input  logic [7:0]            mask_byte,
   input  logic [CMP_W-1:0]      key,
   output logic [ENTRIES-1:0]    mask_q,
   output logic [W-1:0]          rd_data,
   output logic                  hit
);
   initial begin
      if (CMP_W > W) $error("compare width exceeds entry width");
      if (MASK_BYTES * 8 != ENTRIES) $error("entry count must fill whole mask bytes");
      if ((1 << IDX_W) != ENTRIES) $error("entry count must be a power of two");
   end

   logic [W-1:0]       ent_q [ENTRIES];
   logic [ENTRIES-1:0] eq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      end else if (wr_en) begin
         ent_q[idx] <= wr_data;
      end
   end

   for (genvar k = 0; k < MASK_BYTES; k++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)          mask_q[8*k +: 8] <= '0;
         else if (mask_we[k]) mask_q[8*k +: 8] <= mask_byte;
      end
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign eq[i] = (ent_q[i][CMP_W-1:0] == key);
   end

   assign hit     = |(eq & mask_q);
   assign rd_data = ent_q[idx];

   // R7
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !hit);
   // R4
   entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(idx) -> $stable(rd_data)));
   // R4
   entry_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_q[$past(idx)] == $past(wr_data)));
endmodule

// File: rtl/cam_filt_regs.sv
module cam_filt_regs
   import cam_filt_pkg::*;
#(
   parameter int unsigned ENTRIES    = 32,
   parameter int unsigned IDX_W      = $clog2(ENTRIES),
   parameter int unsigned MASK_BYTES = ENTRIES / 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [3:0]            reg_addr,
   input  logic [7:0]            reg_wdata,
   output logic [7:0]            reg_rdata,
   input  logic [MAC_BITS-1:0]   mc_rd,
   input  logic [VL_BITS-1:0]    vl_rd,
   input  logic [ENTRIES-1:0]    mc_mask,
   input  logic [ENTRIES-1:0]    vl_mask,
   output logic [IDX_W-1:0]      idx_q,
   output logic [MAC_BITS-1:0]   win_mac,
   output logic [VL_BITS-1:0]    win_vl,
   output logic                  mc_commit,
   output logic                  vl_commit,
   output logic [MASK_BYTES-1:0] mc_mask_we,
   output logic [MASK_BYTES-1:0] vl_mask_we,
   output logic                  vf_en,
   output logic                  promisc
);
   initial begin
      if (ENTRIES < 8 || ENTRIES > 32) $error("entry count must be 8 to 32");
   end

   logic [3:0] ctl_q;
   logic [1:0] cfg_q;
   logic [7:0] win_q [WIN_BYTES];
   logic       en, sel, wr_go, rd_go, acc;
   logic [31:0] mc_m32, vl_m32, sel_m32;

   assign en    = ctl_q[CTL_EN];
   assign sel   = ctl_q[CTL_SEL];
   assign acc   = reg_wr && en;
   assign wr_go = ctl_q[CTL_WR] && en;
   assign rd_go = ctl_q[CTL_RD] && en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cfg_q <= '0;
         idx_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CTL) ctl_q <= reg_wdata[3:0];
         else                             ctl_q[CTL_RD:CTL_WR] <= 2'b00;
         if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata[1:0];
         if (acc && reg_addr == A_IDX)    idx_q <= reg_wdata[IDX_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WIN_BYTES; i++) win_q[i] <= '0;
      end else if (rd_go) begin
         if (sel) begin
            win_q[VL_LO] <= vl_rd[7:0];
            win_q[VL_HI] <= vl_rd[15:8];
         end else begin
            for (int i = 0; i < MC_BYTES; i++) win_q[i] <= mc_rd[MAC_BITS-1-8*i -: 8];
         end
      end else if (acc && reg_addr < A_MASK0) begin
         win_q[reg_addr[2:0]] <= reg_wdata;
      end
   end

   always_comb begin
      for (int i = 0; i < MC_BYTES; i++) win_mac[MAC_BITS-1-8*i -: 8] = win_q[i];
   end
   assign win_vl    = {win_q[VL_HI], win_q[VL_LO]};
   assign mc_commit = wr_go && !sel;
   assign vl_commit = wr_go && sel;
   assign vf_en     = cfg_q[0];
   assign promisc   = cfg_q[1];

   for (genvar k = 0; k < MASK_BYTES; k++) begin : g_mwe
      assign mc_mask_we[k] = acc && !sel && reg_addr == A_MASK0 + 4'(k);
      assign vl_mask_we[k] = acc &&  sel && reg_addr == A_MASK0 + 4'(k);
   end

   assign mc_m32  = 32'(mc_mask);
   assign vl_m32  = 32'(vl_mask);
   assign sel_m32 = sel ? vl_m32 : mc_m32;

   always_comb begin
      if (reg_addr < A_MASK0)     reg_rdata = win_q[reg_addr[2:0]];
      else if (reg_addr < A_CTL)  reg_rdata = sel_m32[8*reg_addr[1:0] +: 8];
      else if (reg_addr == A_CTL) reg_rdata = {4'b0, ctl_q};
      else if (reg_addr == A_IDX) reg_rdata = 8'(idx_q);
      else if (reg_addr == A_CFG) reg_rdata = {6'b0, cfg_q};
      else                        reg_rdata = '0;
   end

   // R6
   strobe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_WR] && !(reg_wr && reg_addr == A_CTL)) |=> !ctl_q[CTL_WR]);
   // R2
   idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && reg_wr && reg_addr == A_IDX) |=> $stable(idx_q));
endmodule

// File: rtl/cam_rx_filter.sv
module cam_rx_filter
   import cam_filt_pkg::*;
#(
   parameter int unsigned ENTRIES = 32,
   parameter int unsigned VID_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [3:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             frm_valid,
   input  logic [47:0]      frm_dmac,
   input  logic             frm_tagged,
   input  logic [VID_W-1:0] frm_vid,
   output logic             res_valid,
   output logic             res_mc_hit,
   output logic             res_vlan_ok,
   output logic             res_accept
);
   localparam int unsigned IDX_W      = $clog2(ENTRIES);
   localparam int unsigned MASK_BYTES = ENTRIES / 8;

   initial begin
      if (VID_W == 0 || VID_W > VL_BITS) $error("VID width must fit a VLAN entry");
   end

   logic [IDX_W-1:0]      idx_q;
   logic [MAC_BITS-1:0]   win_mac, mc_rd;
   logic [VL_BITS-1:0]    win_vl, vl_rd;
   logic                  mc_commit, vl_commit, vf_en, promisc;
   logic [MASK_BYTES-1:0] mc_mask_we, vl_mask_we;
   logic [ENTRIES-1:0]    mc_mask, vl_mask;
   logic                  mc_hit, vl_hit, vlan_ok;

   cam_filt_regs #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .MASK_BYTES(MASK_BYTES)) regs_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .mc_rd, .vl_rd, .mc_mask, .vl_mask, .idx_q, .win_mac, .win_vl,
      .mc_commit, .vl_commit, .mc_mask_we, .vl_mask_we, .vf_en, .promisc
   );

   cam_filt_table #(.ENTRIES(ENTRIES), .W(MAC_BITS), .CMP_W(MAC_BITS),
                    .IDX_W(IDX_W), .MASK_BYTES(MASK_BYTES)) mc_tbl_i (
      .clk, .rst_n, .wr_en(mc_commit), .idx(idx_q), .wr_data(win_mac),
      .mask_we(mc_mask_we), .mask_byte(reg_wdata), .key(frm_dmac),
      .mask_q(mc_mask), .rd_data(mc_rd), .hit(mc_hit)
   );

   cam_filt_table #(.ENTRIES(ENTRIES), .W(VL_BITS), .CMP_W(VID_W),
                    .IDX_W(IDX_W), .MASK_BYTES(MASK_BYTES)) vl_tbl_i (
      .clk, .rst_n, .wr_en(vl_commit), .idx(idx_q), .wr_data(win_vl),
      .mask_we(vl_mask_we), .mask_byte(reg_wdata), .key(frm_vid),
      .mask_q(vl_mask), .rd_data(vl_rd), .hit(vl_hit)
   );

   assign vlan_ok = !vf_en || !frm_tagged || vl_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_mc_hit  <= 1'b0;
         res_vlan_ok <= 1'b0;
         res_accept  <= 1'b0;
      end else begin
         res_valid   <= frm_valid;
         res_mc_hit  <= frm_valid && mc_hit;
         res_vlan_ok <= frm_valid && vlan_ok;
         res_accept  <= frm_valid && (promisc || (mc_hit && vlan_ok));
      end
   end

   // R10
   promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && promisc) |=> res_accept);
   // R12
   accept_terms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_accept && !$past(promisc)) |-> (res_mc_hit && res_vlan_ok));
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !(res_mc_hit || res_vlan_ok || res_accept));
endmodule

// File: tb/cam_rx_filter_tb.sv
module cam_rx_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        frm_valid = 1'b0;
   logic [47:0] frm_dmac = '0;
   logic        frm_tagged = 1'b0;
   logic [11:0] frm_vid = '0;
   logic        res_valid, res_mc_hit, res_vlan_ok, res_accept;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [47:0] mc_m [32];
   logic [15:0] vl_m [32];
   logic [31:0] mcmask = '0, vlmask = '0;
   bit          vf = 1'b0, pr = 1'b0;

   always #2 clk = ~clk;

   cam_rx_filter dut_i (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .frm_valid, .frm_dmac, .frm_tagged, .frm_vid,
      .res_valid, .res_mc_hit, .res_vlan_ok, .res_accept
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !done) begin
         fails = fails + 1;
         $display("FAIL watchdog act=hung exp=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic put_entry(input bit sel, input logic [7:0] idx, input logic [47:0] val);
      wr(4'hC, {6'b0, sel, 1'b1});
      wr(4'hD, idx);
      if (!sel) begin
         for (int b = 0; b < 6; b++) wr(4'(b), val[47-8*b -: 8]);
         mc_m[idx[4:0]] = val;
      end else begin
         wr(4'h6, val[7:0]);
         wr(4'h7, val[15:8]);
         vl_m[idx[4:0]] = val[15:0];
      end
      wr(4'hC, {5'b0, 1'b1, sel, 1'b1});
      wr(4'hC, 8'h00);
   endtask

   task automatic set_mask(input bit sel, input logic [31:0] m);
      wr(4'hC, {6'b0, sel, 1'b1});
      for (int k = 0; k < 4; k++) wr(4'(8 + k), m[8*k +: 8]);
      wr(4'hC, 8'h00);
      if (sel) vlmask = m; else mcmask = m;
   endtask

   task automatic set_cfg(input bit v, input bit p);
      wr(4'hE, {6'b0, p, v});
      vf = v; pr = p;
   endtask

   function automatic bit exp_mc(input logic [47:0] d);
      bit h = 0;
      for (int i = 0; i < 32; i++) if (mcmask[i] && mc_m[i] == d) h = 1;
      return h;
   endfunction

   function automatic bit exp_vok(input bit t, input logic [11:0] v);
      bit h = 0;
      for (int i = 0; i < 32; i++) if (vlmask[i] && vl_m[i][11:0] == v) h = 1;
      return !vf || !t || h;
   endfunction

   task automatic frame(input string req, input logic [47:0] d, input bit t, input logic [11:0] v);
      bit em, ev;
      em = exp_mc(d);
      ev = exp_vok(t, v);
      @(negedge clk);
      frm_valid = 1'b1; frm_dmac = d; frm_tagged = t; frm_vid = v;
      @(negedge clk);
      frm_valid = 1'b0;
      chk({req, " R12 valid"}, 64'(res_valid), 64'd1);
      chk({req, " R8 mc_hit"}, 64'(res_mc_hit), 64'(em));
      chk({req, " R9 vlan_ok"}, 64'(res_vlan_ok), 64'(ev));
      chk({req, " R12 accept"}, 64'(res_accept), 64'(pr || (em && ev)));
   endtask

   initial begin
      logic [7:0]  r;
      logic [47:0] ea, eb, ec, ed, dm;
      logic [11:0] vv;
      int n, m;
      void'($urandom(32'd7321));
      for (int i = 0; i < 32; i++) begin mc_m[i] = '0; vl_m[i] = '0; end
      ea = 48'h01005E_112233;
      eb = 48'h333300_0000FB;
      ec = 48'h01005E_7F0001;
      ed = 48'hAB1234_56789A;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 res_valid", 64'(res_valid), 0);
      rd(4'hC, r); chk("R1 ctl", 64'(r), 0);
      rd(4'hD, r); chk("R1 idx", 64'(r), 0);
      rd(4'h8, r); chk("R1 mask", 64'(r), 0);
      rd(4'hE, r); chk("R1 cfg", 64'(r), 0);
      rd(4'h3, r); chk("R1 window", 64'(r), 0);

      // R2 writes ignored without enable
      wr(4'hD, 8'h09); rd(4'hD, r); chk("R2 idx gated", 64'(r), 0);
      wr(4'h8, 8'hFF); rd(4'h8, r); chk("R2 mask gated", 64'(r), 0);
      wr(4'h0, 8'hAA); rd(4'h0, r); chk("R2 window gated", 64'(r), 0);

      // R3 index high bits dropped
      wr(4'hC, 8'h01); wr(4'hD, 8'h25); rd(4'hD, r); chk("R3 idx wrap", 64'(r), 64'h05);
      wr(4'hC, 8'h00);

      // R4 R5 R8 multicast load and compare
      put_entry(0, 8'h00, ea);
      put_entry(0, 8'h41, eb);
      set_mask(0, 32'h3);
      frame("R4 entry0", ea, 0, 0);
      frame("R5 entry1", eb, 0, 0);
      frame("R8 lsb diff", ea ^ 48'h1, 0, 0);
      frame("R8 msb diff", ea ^ 48'h8000_0000_0000, 0, 0);

      // R7 mask
      set_mask(0, 32'h2);
      frame("R7 masked entry0", ea, 0, 0);
      frame("R7 enabled entry1", eb, 0, 0);
      set_mask(0, 32'h0);
      frame("R7 zero mask", eb, 0, 0);
      chk("R7 zero mask miss", 64'(res_mc_hit), 0);

      // R3 store at index modulo 32
      put_entry(0, 8'h43, ec);
      set_mask(0, 32'hB);
      frame("R3 entry3", ec, 0, 0);
      chk("R3 entry3 hit", 64'(res_mc_hit), 1);

      // R4 strobe without enable ignored
      wr(4'hC, 8'h01); wr(4'hD, 8'h00);
      for (int b = 0; b < 6; b++) wr(4'(b), ed[47-8*b -: 8]);
      wr(4'hC, 8'h04); wr(4'hC, 8'h00);
      frame("R4 no commit new", ed, 0, 0);
      chk("R4 no commit miss", 64'(res_mc_hit), 0);
      frame("R4 no commit old", ea, 0, 0);
      chk("R4 old kept", 64'(res_mc_hit), 1);

      // R6 R11 read strobe and self-clear
      wr(4'hC, 8'h01); wr(4'hD, 8'h00);
      wr(4'hC, 8'h09);
      rd(4'hC, r); chk("R6 strobe visible", 64'(r), 64'h09);
      @(negedge clk);
      rd(4'hC, r); chk("R6 strobe cleared", 64'(r), 64'h01);
      for (int b = 0; b < 6; b++) begin
         rd(4'(b), r); chk("R11 mc readback", 64'(r), 64'(ea[47-8*b -: 8]));
      end
      wr(4'hC, 8'h00);

      // R5 R9 VLAN table
      put_entry(1, 8'h00, 48'h0064);
      put_entry(1, 8'h01, 48'hF123);
      set_mask(1, 32'h3);
      set_cfg(1, 0);
      frame("R9 vid in", ea, 1, 12'h064);
      frame("R9 low12 only", ea, 1, 12'h123);
      chk("R9 low12 pass", 64'(res_vlan_ok), 1);
      frame("R9 vid out", ea, 1, 12'h065);
      chk("R9 reject", 64'(res_accept), 0);
      frame("R9 untagged", ea, 0, 12'h065);
      set_cfg(0, 0);
      frame("R9 filter off", ea, 1, 12'h065);

      // R11 VLAN readback, R7 mask steering
      wr(4'hC, 8'h03); wr(4'hD, 8'h01); wr(4'hC, 8'h0B);
      @(negedge clk);
      rd(4'h6, r); chk("R11 vl low", 64'(r), 64'h23);
      rd(4'h7, r); chk("R11 vl high", 64'(r), 64'hF1);
      rd(4'h8, r); chk("R7 vl mask read", 64'(r), 64'h03);
      wr(4'hC, 8'h01);
      rd(4'h8, r); chk("R7 mc mask read", 64'(r), 64'h0B);
      wr(4'hC, 8'h00);

      // R10 promiscuous
      set_cfg(1, 1);
      frame("R10 promisc", ed, 1, 12'h999);
      chk("R10 accept", 64'(res_accept), 1);
      set_cfg(0, 0);

      // random rounds, tables filled from index 0
      for (int rnd = 0; rnd < 6; rnd++) begin
         n = $urandom_range(1, 32);
         m = $urandom_range(1, 32);
         for (int i = 0; i < n; i++) put_entry(0, 8'(i), {16'($urandom), 32'($urandom)});
         for (int i = 0; i < m; i++) put_entry(1, 8'(i), 48'(16'($urandom)));
         set_mask(0, (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1));
         set_mask(1, (m == 32) ? 32'hFFFF_FFFF : ((32'h1 << m) - 1));
         set_cfg(1'($urandom), ($urandom_range(0, 3) == 0));
         for (int f = 0; f < 20; f++) begin
            dm = $urandom_range(0, 1) ? mc_m[$urandom_range(0, 31)] : {16'($urandom), 32'($urandom)};
            vv = $urandom_range(0, 1) ? vl_m[$urandom_range(0, 31)][11:0] : 12'($urandom);
            frame("R8 R9 R12 random", dm, 1'($urandom), vv);
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule